// File: doc/BRIEF.md
# Unique-Word Frame Synchronizer

This block sets up frame timing for a time-division radio link. It watches the recovered bit stream one bit per strobe, keeps the most recent bits in a history register, and compares that history with one of two fixed sync patterns. A single select input chooses the pattern. When the pattern turns up, the block stores the current frame-counter value as the sync location and raises a sticky acquisition flag. Software clears that flag with a pulse.

There are two search modes. A full search accepts the pattern at any frame position and is used for first acquisition. A window search accepts the pattern only when the frame counter lies near the stored location, within half of a programmable window span. Once a location is known, the block also raises a sticky frame-start flag each time the frame counter passes that location on a bit strobe. The flag is cleared by its own pulse.

Top module: `uw_frame_sync`

## Requirements
- R1: After reset, `acq_flag` and `fs_flag` are 0, `sync_loc` is 0, the bit history holds all zeros, and no location is known yet.
- R2: The history shifts in `rx_bit` only in cycles with `rx_bit_stb` = 1; the newest bit enters at the LSB, so a pattern is sent MSB first. `rx_bit` in a cycle without a strobe has no effect.
- R3: With `pat_sel` = 0 only PAT_A (default 16'h3A5C) is searched for, and with `pat_sel` = 1 only PAT_B (default 16'hC6F1). The other pattern is never detected.
- R4: With `win_mode` = 0 (full search), a strobe that makes the last 16 received bits equal the selected pattern is a valid match at any frame position. On the next clock edge `sync_loc` takes the `frame_pos` value present with that strobe, and `acq_flag` becomes 1.
- R5: With `win_mode` = 1 (window search), a match is valid only if D ≤ floor(`win_span`/2), where D is the smaller of (`frame_pos` − `sync_loc`) mod 512 and (`sync_loc` − `frame_pos`) mod 512. Matches outside this window change neither `sync_loc` nor `acq_flag`. Before the first acquisition the window is centred on location 0.
- R6: `acq_clr` = 1 clears `acq_flag` on the next edge, unless a valid match occurs in the same cycle. A valid match takes priority and leaves the flag set.
- R7: Once any valid match has occurred, a strobe with `frame_pos` equal to `sync_loc` (the value before that edge) sets `fs_flag`. `fs_clr` clears `fs_flag`, and a set in the same cycle takes priority.
- R8: `sync_loc` changes only on a valid match. It holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received data bit |
| rx_bit_stb | input | 1 | Marks the cycle in which `rx_bit` is valid |
| frame_pos | input | 9 | Current frame counter value |
| win_mode | input | 1 | 0 = full search, 1 = window search |
| pat_sel | input | 1 | 0 selects PAT_A, 1 selects PAT_B |
| win_span | input | 9 | Window size in frame positions |
| acq_clr | input | 1 | Clear pulse for `acq_flag` |
| fs_clr | input | 1 | Clear pulse for `fs_flag` |
| acq_flag | output | 1 | Sticky sync-acquired indicator |
| fs_flag | output | 1 | Sticky frame-start indicator |
| sync_loc | output | 9 | Frame position where the pattern was last accepted |

## Verification
The bench builds the block with its default parameters: 16-bit patterns 16'h3A5C and 16'hC6F1, 9-bit positions, and circular window distance. A 9-bit position space lets the bench put the frame counter on either side of the 511-to-0 wrap within a few cycles, so windows that straddle the wrap are tested directly. The two defaults differ in most bits, so sending the unselected pattern is a clean negative case. Directed cases hit the window edge at exactly half the span and one step past it. They also cover a set and a clear in the same cycle for both flags.

// File: rtl/uw_sync_pkg.sv
package uw_sync_pkg;
   typedef enum logic {
      SRCH_FULL = 1'b0,
      SRCH_WIN  = 1'b1
   } srch_mode_e;

   localparam int          DEF_PAT_W = 16;
   localparam logic [15:0] DEF_PAT_A = 16'h3A5C;
   localparam logic [15:0] DEF_PAT_B = 16'hC6F1;
endpackage

// File: rtl/uw_shift_match.sv
module uw_shift_match #(
   parameter int                PAT_W = 16,
   parameter logic [PAT_W-1:0]  PAT_A = 16'h3A5C,
   parameter logic [PAT_W-1:0]  PAT_B = 16'hC6F1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_bit,
   input  logic rx_bit_stb,
   input  logic pat_sel,
   output logic hit
);
   logic [PAT_W-1:0] hist_q;
   logic [PAT_W-1:0] hist_d;
   logic [PAT_W-1:0] pat;
   logic [PAT_W-1:0] eq_vec;

   generate
      if (PAT_W < 2) begin : g_bad_w
         $error("uw_shift_match: PAT_W must be at least 2");
      end
      if (PAT_A == PAT_B) begin : g_bad_pat
         $error("uw_shift_match: the two patterns must differ");
      end
   endgenerate

   // Newest bit enters at the LSB
   assign hist_d = {hist_q[PAT_W-2:0], rx_bit};
   assign pat    = pat_sel ? PAT_B : PAT_A;

   generate
      for (genvar i = 0; i < PAT_W; i++) begin : g_eq
         assign eq_vec[i] = ~(hist_d[i] ^ pat[i]);
      end
   endgenerate

   assign hit = rx_bit_stb & (&eq_vec);

   always_ff @(posedge clk) begin
      if (!rst_n)          hist_q <= '0;
      else if (rx_bit_stb) hist_q <= hist_d;
   end

   // R2: history frozen without a strobe
   assert_hist_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_bit_stb |=> $stable(hist_q));
   // R2: on a strobe the newest bit lands at the LSB
   assert_hist_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_bit_stb |=> hist_q[0] == $past(rx_bit));
endmodule

// File: rtl/uw_window_gate.sv
module uw_window_gate #(
   parameter int LOC_W    = 9,
   parameter bit CIRCULAR = 1'b1
) (
   input  logic [LOC_W-1:0] frame_pos,
   input  logic [LOC_W-1:0] anchor,
   input  logic [LOC_W-1:0] win_span,
   output logic             in_win
);
   logic [LOC_W-1:0] half;
   logic [LOC_W-1:0] fwd;
   logic [LOC_W-1:0] back;

   generate
      if (LOC_W < 2) begin : g_bad_w
         $error("uw_window_gate: LOC_W must be at least 2");
      end
   endgenerate

   assign half = win_span >> 1;
   assign fwd  = frame_pos - anchor;
   assign back = anchor - frame_pos;

   generate
      if (CIRCULAR) begin : g_circ
         assign in_win = (fwd <= half) || (back <= half);
      end else begin : g_lin
         assign in_win = ((frame_pos >= anchor) ? fwd : back) <= half;
      end
   endgenerate
endmodule

// File: rtl/uw_sticky_flag.sv
module uw_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)    flag <= 1'b0;
      else if (set)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end

   // R6: set beats a same-cycle clear
   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);
   // R6: clear without set drops the flag
   assert_clr_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);
   // R6: flag is sticky otherwise
   assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !set) |=> $stable(flag));
endmodule

// File: rtl/uw_frame_sync.sv
module uw_frame_sync #(
   parameter int                PAT_W    = uw_sync_pkg::DEF_PAT_W,
   parameter logic [PAT_W-1:0]  PAT_A    = uw_sync_pkg::DEF_PAT_A,
   parameter logic [PAT_W-1:0]  PAT_B    = uw_sync_pkg::DEF_PAT_B,
   parameter int                LOC_W    = 9,
   parameter bit                CIRCULAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_bit,
   input  logic             rx_bit_stb,
   input  logic [LOC_W-1:0] frame_pos,
   input  logic             win_mode,
   input  logic             pat_sel,
   input  logic [LOC_W-1:0] win_span,
   input  logic             acq_clr,
   input  logic             fs_clr,
   output logic             acq_flag,
   output logic             fs_flag,
   output logic [LOC_W-1:0] sync_loc
);
   import uw_sync_pkg::*;

   srch_mode_e       mode;
   logic             pat_hit;
   logic             in_win;
   logic             match_ok;
   logic             have_loc_q;
   logic             fs_set;
   logic [LOC_W-1:0] loc_q;

   assign mode = srch_mode_e'(win_mode);

   uw_shift_match #(
      .PAT_W (PAT_W),
      .PAT_A (PAT_A),
      .PAT_B (PAT_B)
   ) match_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_bit     (rx_bit),
      .rx_bit_stb (rx_bit_stb),
      .pat_sel    (pat_sel),
      .hit        (pat_hit)
   );

   uw_window_gate #(
      .LOC_W    (LOC_W),
      .CIRCULAR (CIRCULAR)
   ) win_i (
      .frame_pos (frame_pos),
      .anchor    (loc_q),
      .win_span  (win_span),
      .in_win    (in_win)
   );

   assign match_ok = pat_hit && ((mode == SRCH_FULL) || in_win);
   assign fs_set   = rx_bit_stb && have_loc_q && (frame_pos == loc_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc_q      <= '0;
         have_loc_q <= 1'b0;
      end else if (match_ok) begin
         loc_q      <= frame_pos;
         have_loc_q <= 1'b1;
      end
   end

   uw_sticky_flag acq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (match_ok),
      .clr   (acq_clr),
      .flag  (acq_flag)
   );

   uw_sticky_flag fs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (fs_set),
      .clr   (fs_clr),
      .flag  (fs_flag)
   );

   assign sync_loc = loc_q;

   // R8: no strobe, no location change
   assert_loc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_bit_stb |=> $stable(sync_loc));
   // R5: out-of-window hit in window mode is ignored
   assert_win_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_bit_stb && win_mode && !in_win) |=> $stable(sync_loc));
   // R4: an accepted match captures the frame position and flags acquisition
   assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      match_ok |=> (sync_loc == $past(frame_pos)) && acq_flag);
   // R7: reaching the stored location on a strobe raises frame start
   assert_fs_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_bit_stb && have_loc_q && frame_pos == sync_loc) |=> fs_flag);
   // R1: flags low right after reset
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> !acq_flag && !fs_flag && sync_loc == '0);
endmodule

// File: tb/uw_frame_sync_tb_top.sv
module uw_frame_sync_tb_top;
   localparam logic [15:0] WA = 16'h3A5C;
   localparam logic [15:0] WB = 16'hC6F1;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       rx_bit, rx_bit_stb, win_mode, pat_sel, acq_clr, fs_clr;
   logic [8:0] frame_pos, win_span;
   logic       acq_flag, fs_flag;
   logic [8:0] sync_loc;

   int n_chk = 0;
   int n_bad = 0;

   // bench-side model state
   logic [15:0] m_sh;
   logic        m_acq, m_fs, m_have;
   logic [8:0]  m_loc;
   logic [8:0]  fc;

   always #2 clk = ~clk;

   uw_frame_sync dut_i (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_stb(rx_bit_stb),
      .frame_pos(frame_pos), .win_mode(win_mode), .pat_sel(pat_sel),
      .win_span(win_span), .acq_clr(acq_clr), .fs_clr(fs_clr),
      .acq_flag(acq_flag), .fs_flag(fs_flag), .sync_loc(sync_loc)
   );

   task automatic check(input string req, input string what,
                        input logic [8:0] got, input logic [8:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   function automatic logic in_window(input logic [8:0] p, input logic [8:0] a,
                                      input logic [8:0] span);
      logic [8:0] d1, d2, h;
      d1 = p - a;
      d2 = a - p;
      h  = span >> 1;
      return (d1 <= h) || (d2 <= h);
   endfunction

   // one clock: drive at negedge, predict, compare after posedge
   task automatic cyc(input logic stb, input logic b, input logic aclr,
                      input logic fclr, input string req);
      logic [15:0] nsh;
      logic        hit, ok, fset;
      @(negedge clk);
      rx_bit_stb = stb; rx_bit = b; acq_clr = aclr; fs_clr = fclr;
      frame_pos  = fc;
      nsh  = stb ? {m_sh[14:0], b} : m_sh;
      hit  = stb && (nsh == (pat_sel ? WB : WA));
      ok   = hit && (!win_mode || in_window(fc, m_loc, win_span));
      fset = stb && m_have && (fc == m_loc);
      m_fs  = fset ? 1'b1 : (fclr ? 1'b0 : m_fs);
      m_acq = ok   ? 1'b1 : (aclr ? 1'b0 : m_acq);
      if (ok) begin m_loc = fc; m_have = 1'b1; end
      m_sh = nsh;
      @(posedge clk); #1;
      check(req, "acq_flag", {8'd0, acq_flag}, {8'd0, m_acq});
      check(req, "fs_flag",  {8'd0, fs_flag},  {8'd0, m_fs});
      check(req, "sync_loc", sync_loc, m_loc);
      if (stb) fc = fc + 9'd1;
   endtask

   // send a pattern MSB first; last bit lands at frame position 'endpos'
   task automatic send_pat(input logic [15:0] w, input logic [8:0] endpos,
                           input logic aclr_last, input string req);
      fc = endpos - 9'd15;
      for (int i = 15; i >= 0; i--)
         cyc(1'b1, w[i], (i == 0) ? aclr_last : 1'b0, 1'b0, req);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; rx_bit = 0; rx_bit_stb = 0; win_mode = 0; pat_sel = 0;
      acq_clr = 0; fs_clr = 0; frame_pos = 0; win_span = 9'd20;
      m_sh = '0; m_acq = 0; m_fs = 0; m_have = 0; m_loc = 0; fc = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R1", "acq_flag", {8'd0, acq_flag}, 9'd0);
      check("R1", "fs_flag",  {8'd0, fs_flag},  9'd0);
      check("R1", "sync_loc", sync_loc, 9'd0);
      @(negedge clk); rst_n = 1'b1;

      // R2: first 15 bits, idle cycles with noise, then the final bit
      fc = 9'd100;
      for (int i = 15; i >= 1; i--) cyc(1'b1, WA[i], 0, 0, "R2");
      for (int k = 0; k < 8; k++) cyc(1'b0, k[0], 0, 0, "R2");
      check("R2", "acq_before_last", {8'd0, acq_flag}, 9'd0);
      cyc(1'b1, WA[0], 0, 0, "R2");
      check("R2", "acq_after_last", {8'd0, acq_flag}, 9'd1);
      check("R2", "loc_after_last", sync_loc, 9'd115);

      // R6 clear, then R3: unselected pattern ignored
      cyc(1'b0, 0, 1, 0, "R6");
      check("R6", "acq_cleared", {8'd0, acq_flag}, 9'd0);
      pat_sel = 0;
      send_pat(WB, 9'd200, 0, "R3");
      check("R3", "wrong_pat_acq", {8'd0, acq_flag}, 9'd0);
      check("R3", "wrong_pat_loc", sync_loc, 9'd115);
      pat_sel = 1;
      send_pat(WB, 9'd210, 0, "R3");
      check("R3", "sel_pat_loc", sync_loc, 9'd210);

      // R4: full search at arbitrary positions; R6 set beats clear
      pat_sel = 0;
      send_pat(WA, 9'd37, 1, "R6");
      check("R6", "set_over_clr", {8'd0, acq_flag}, 9'd1);
      send_pat(WA, 9'd400, 0, "R4");
      check("R4", "full_loc", sync_loc, 9'd400);

      // R5: window, span 20 -> half 10, around 400
      win_mode = 1; win_span = 9'd20;
      cyc(1'b0, 0, 1, 0, "R5");
      send_pat(WA, 9'd411, 0, "R5");
      check("R5", "outside_loc", sync_loc, 9'd400);
      check("R5", "outside_acq", {8'd0, acq_flag}, 9'd0);
      send_pat(WA, 9'd410, 0, "R5");
      check("R5", "edge_loc", sync_loc, 9'd410);
      // wrap: move to 3 via full search, then hit at 505 (distance 10)
      win_mode = 0; send_pat(WA, 9'd3, 0, "R4");
      win_mode = 1;
      send_pat(WA, 9'd505, 0, "R5");
      check("R5", "wrap_loc", sync_loc, 9'd505);
      send_pat(WA, 9'd494, 0, "R5");
      check("R5", "wrap_out_loc", sync_loc, 9'd505);

      // R7: frame start at stored location, clear, set over clear
      win_mode = 0;
      fc = 9'd500;
      for (int k = 0; k < 8; k++) cyc(1'b1, 0, 0, 0, "R7");
      check("R7", "fs_set", {8'd0, fs_flag}, 9'd1);
      cyc(1'b0, 0, 0, 1, "R7");
      check("R7", "fs_cleared", {8'd0, fs_flag}, 9'd0);
      fc = 9'd505;
      cyc(1'b1, 0, 0, 1, "R7");
      check("R7", "fs_set_over_clr", {8'd0, fs_flag}, 9'd1);

      // R8 plus mixed random traffic
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 3) begin
            win_mode = $urandom_range(0, 1);
            pat_sel  = $urandom_range(0, 1);
            win_span = 9'($urandom_range(0, 511));
            send_pat(pat_sel ? WB : WA, 9'($urandom_range(0, 511)),
                     1'($urandom_range(0, 1)), "R4");
         end else if (r < 5) begin
            fc = 9'($urandom_range(0, 511));
         end else begin
            cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 15) == 0), 1'($urandom_range(0, 15) == 0),
                "R8");
         end
      end
      finish_run();
   end
endmodule